// File: doc/BRIEF.md
# External Reset Pin Status and Interrupt

This block watches an asynchronous, active-low external reset pin from inside the master clock domain. It brings the pin through a resynchronizer and publishes its current level. It also raises a sticky flag whenever the synchronized pin goes from high to low. Software clears that flag by reading the status word.

The flag can drive an interrupt. The interrupt is active only when the pin is not configured to cause a reset (user-reset enable cleared) and the interrupt enable is set.

The status word also carries two more fields. One is a busy bit for a software reset command: it is set when such a command is accepted and cleared when the reset sequencer reports completion. The other is a 3-bit cause-of-last-reset field, which the reset sequencer loads through a strobed input. A mode register holds the user-reset enable and the interrupt enable, and is written with a one-cycle strobe.

Top module: `rstpin_status`

## Requirements
- R1: The pin passes through two flip-flop stages clocked on the rising clock edge. A pin change made between two edges first appears in the level bit after the second following rising edge, and not after the first.
- R2: The level bit (status bit 16) reports the synchronized pin value on every cycle, in both directions.
- R3: A high-to-low change of the level bit sets the sticky flag (status bit 0) on the next rising edge. The flag stays set after the pin returns high.
- R4: `irq_o` is high only while the flag is set, user-reset enable is 0 and interrupt enable is 1. The mode register is written from `mode_ue_i`/`mode_ie_i` on an edge where `mode_wr_i` is high, and the new values take effect from that edge.
- R5: An edge where `stat_rd_i` is high clears the flag, and with it `irq_o`, unless a new fall is detected in that same cycle.
- R6: A software reset request while not busy produces a one-cycle `swrst_go_o` pulse in that cycle and sets the busy bit (status bit 17) on the edge. `swrst_done_i` while busy clears the busy bit on the edge.
- R7: On an edge with `rtype_ld_i` high, the reset-type field (status bits 10:8) takes `rtype_i`. Without the strobe the field holds its value.
- R8: If a read and a newly detected fall occur in the same cycle, the flag is set after the edge.
- R9: A software reset request while the busy bit is set gives no `swrst_go_o` pulse and leaves the busy bit set.
- R10: After reset the status word is 32'h0001_0000, meaning level 1, flag 0, busy 0 and type 0. `irq_o` is 0, both mode bits are 0, and status bits outside 0, 10:8, 16 and 17 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_rst_n_i | input | 1 | Asynchronous external reset pin, active low |
| mode_wr_i | input | 1 | Mode register write strobe |
| mode_ue_i | input | 1 | User-reset enable write data |
| mode_ie_i | input | 1 | Interrupt enable write data |
| stat_rd_i | input | 1 | Status read strobe; clears the flag |
| stat_rdata_o | output | 32 | Status word |
| swrst_req_i | input | 1 | Software reset command request |
| swrst_done_i | input | 1 | Software reset finished, from sequencer |
| swrst_go_o | output | 1 | Accepted software reset start pulse |
| rtype_ld_i | input | 1 | Reset-type load strobe |
| rtype_i | input | 3 | Reset-type value to load |
| irq_o | output | 1 | Pin-fall interrupt |

## Verification
A pin change reaches the level bit two rising edges later. The flag and interrupt follow on the third edge. Mode writes, reads, type loads and busy changes take effect on the first edge after their strobe. `swrst_go_o` is combinational and valid in the same cycle as the request. The bench drives every input at a falling edge, steps a counted number of falling edges, and samples there. It also checks the level one edge early, to confirm it has not yet moved.

// File: rtl/rstpin_pkg.sv
// Package: shared widths, status bit positions and the status packing function.
// Assumes a 32-bit status word; the field positions are fixed by software.
package rstpin_pkg;
    localparam int STAT_W    = 32;
    localparam int RTYPE_W   = 3;
    localparam int POS_FLAG  = 0;
    localparam int POS_RTYPE = 8;
    localparam int POS_LEVEL = 16;
    localparam int POS_BUSY  = 17;

    typedef struct packed {
        logic               busy;
        logic               level;
        logic [RTYPE_W-1:0] rtype;
        logic               flag;
    } stat_fields_t;

    // Places each field at its bit position; all other bits read as zero.
    function automatic logic [STAT_W-1:0] pack_status(input stat_fields_t f);
        logic [STAT_W-1:0] w;
        w = '0;
        w[POS_FLAG]                       = f.flag;
        w[POS_RTYPE +: RTYPE_W]           = f.rtype;
        w[POS_LEVEL]                      = f.level;
        w[POS_BUSY]                       = f.busy;
        return w;
    endfunction
endpackage

// File: rtl/rstpin_sync.sv
// Module: multi-stage resynchronizer for an asynchronous level.
// Assumes STAGES >= 2; all stages reset to RESET_VAL so no false edge
// is seen when the input idles at that value.
module rstpin_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain;

    // Shift the async input through the stage chain each rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RESET_VAL}};
        else        chain <= {chain[STAGES-2:0], async_i};
    end

    assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/rstpin_edge_flag.sv
// Module: falling-edge detector with a sticky, read-clear flag.
// Assumes level_i is already synchronous; a set in the same cycle as a
// clear takes priority so that no event is lost.
module rstpin_edge_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    input  logic clr_i,
    output logic fall_o,
    output logic flag_o
);
    logic prev_q;

    // Remember the last synchronized level (idle high after reset).
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= level_i;
    end

    assign fall_o = prev_q & ~level_i;

    // Sticky flag: set on a fall, clear on read, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)      flag_o <= 1'b0;
        else if (fall_o) flag_o <= 1'b1;
        else if (clr_i)  flag_o <= 1'b0;
    end
endmodule

// File: rtl/rstpin_swrst.sv
// Module: software reset command tracker.
// Assumes the sequencer raises done_i once when the command finishes;
// requests while busy are dropped, done while idle has no effect.
module rstpin_swrst (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic done_i,
    output logic go_o,
    output logic busy_o
);
    assign go_o = req_i & ~busy_o;

    // Busy rises on an accepted request and falls on completion.
    always_ff @(posedge clk) begin
        if (!rst_n)                busy_o <= 1'b0;
        else if (go_o)             busy_o <= 1'b1;
        else if (done_i && busy_o) busy_o <= 1'b0;
    end
endmodule

// File: rtl/rstpin_regs.sv
// Module: mode register, reset-type holder, status assembly and interrupt gate.
// Assumes strobes are single-cycle and synchronous to clk.
module rstpin_regs
    import rstpin_pkg::*;
#(
    parameter logic [RTYPE_W-1:0] RTYPE_RST = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode_wr_i,
    input  logic               mode_ue_i,
    input  logic               mode_ie_i,
    input  logic               rtype_ld_i,
    input  logic [RTYPE_W-1:0] rtype_i,
    input  logic               flag_i,
    input  logic               level_i,
    input  logic               busy_i,
    output logic [STAT_W-1:0]  stat_o,
    output logic               irq_o
);
    logic               ue_q;
    logic               ie_q;
    logic [RTYPE_W-1:0] rtype_q;
    stat_fields_t       fields;

    // Mode register: user-reset enable and interrupt enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ue_q <= 1'b0;
            ie_q <= 1'b0;
        end else if (mode_wr_i) begin
            ue_q <= mode_ue_i;
            ie_q <= mode_ie_i;
        end
    end

    // Cause-of-last-reset holder, loaded by the sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n)          rtype_q <= RTYPE_RST;
        else if (rtype_ld_i) rtype_q <= rtype_i;
    end

    // Gather the fields into the status word.
    always_comb begin
        fields.busy  = busy_i;
        fields.level = level_i;
        fields.rtype = rtype_q;
        fields.flag  = flag_i;
        stat_o       = pack_status(fields);
    end

    assign irq_o = flag_i & ~ue_q & ie_q;
endmodule

// File: rtl/rstpin_status.sv
// Module: top of the external reset pin status block.
// Assumes ext_rst_n_i is fully asynchronous and idles high.
module rstpin_status
    import rstpin_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ext_rst_n_i,
    input  logic               mode_wr_i,
    input  logic               mode_ue_i,
    input  logic               mode_ie_i,
    input  logic               stat_rd_i,
    output logic [STAT_W-1:0]  stat_rdata_o,
    input  logic               swrst_req_i,
    input  logic               swrst_done_i,
    output logic               swrst_go_o,
    input  logic               rtype_ld_i,
    input  logic [RTYPE_W-1:0] rtype_i,
    output logic               irq_o
);
    logic level;
    logic fall;
    logic flag;
    logic busy;

    rstpin_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(ext_rst_n_i), .sync_o(level)
    );

    rstpin_edge_flag u_edge (
        .clk(clk), .rst_n(rst_n), .level_i(level), .clr_i(stat_rd_i),
        .fall_o(fall), .flag_o(flag)
    );

    rstpin_swrst u_swrst (
        .clk(clk), .rst_n(rst_n), .req_i(swrst_req_i), .done_i(swrst_done_i),
        .go_o(swrst_go_o), .busy_o(busy)
    );

    rstpin_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .mode_wr_i(mode_wr_i), .mode_ue_i(mode_ue_i), .mode_ie_i(mode_ie_i),
        .rtype_ld_i(rtype_ld_i), .rtype_i(rtype_i),
        .flag_i(flag), .level_i(level), .busy_i(busy),
        .stat_o(stat_rdata_o), .irq_o(irq_o)
    );

    logic unused_fall;
    assign unused_fall = fall;
endmodule

// File: rtl/rstpin_status_chk.sv
// Checker: temporal properties of rstpin_status, observed at its ports.
module rstpin_status_chk
    import rstpin_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               stat_rd_i,
    input logic               swrst_req_i,
    input logic               swrst_done_i,
    input logic               swrst_go_o,
    input logic               rtype_ld_i,
    input logic [RTYPE_W-1:0] rtype_i,
    input logic [STAT_W-1:0]  stat_rdata_o,
    input logic               irq_o
);
    localparam logic [STAT_W-1:0] USED =
        (STAT_W'(1) << POS_FLAG) | (STAT_W'(1) << POS_LEVEL) |
        (STAT_W'(1) << POS_BUSY) | (STAT_W'((1 << RTYPE_W) - 1) << POS_RTYPE);

    assert_flag_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_rdata_o[POS_LEVEL] && $past(stat_rdata_o[POS_LEVEL])) |=> stat_rdata_o[POS_FLAG]);

    assert_irq_needs_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> stat_rdata_o[POS_FLAG]);

    assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd_i && !(!stat_rdata_o[POS_LEVEL] && $past(stat_rdata_o[POS_LEVEL])))
        |=> (!stat_rdata_o[POS_FLAG] && !irq_o));

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd_i && !stat_rdata_o[POS_LEVEL] && $past(stat_rdata_o[POS_LEVEL]))
        |=> stat_rdata_o[POS_FLAG]);

    assert_go_sets_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        swrst_go_o |=> stat_rdata_o[POS_BUSY]);

    assert_done_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (swrst_done_i && stat_rdata_o[POS_BUSY]) |=> !stat_rdata_o[POS_BUSY]);

    assert_busy_drops_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (swrst_req_i && stat_rdata_o[POS_BUSY]) |-> !swrst_go_o);

    assert_rtype_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rtype_ld_i |=> (stat_rdata_o[POS_RTYPE +: RTYPE_W] == $past(rtype_i)));

    assert_rtype_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rtype_ld_i |=> $stable(stat_rdata_o[POS_RTYPE +: RTYPE_W]));

    assert_rsvd_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rdata_o & ~USED) == '0);
endmodule

bind rstpin_status rstpin_status_chk u_chk (
    .clk(clk), .rst_n(rst_n), .stat_rd_i(stat_rd_i),
    .swrst_req_i(swrst_req_i), .swrst_done_i(swrst_done_i),
    .swrst_go_o(swrst_go_o), .rtype_ld_i(rtype_ld_i), .rtype_i(rtype_i),
    .stat_rdata_o(stat_rdata_o), .irq_o(irq_o)
);

// File: tb/rstpin_status_bench.sv
module rstpin_status_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_rst_n_i = 1'b1;
    logic        mode_wr_i = 1'b0, mode_ue_i = 1'b0, mode_ie_i = 1'b0;
    logic        stat_rd_i = 1'b0;
    logic [31:0] stat_rdata_o;
    logic        swrst_req_i = 1'b0, swrst_done_i = 1'b0, swrst_go_o;
    logic        rtype_ld_i = 1'b0;
    logic [2:0]  rtype_i = 3'd0;
    logic        irq_o;
    int          total = 0;
    int          bad = 0;

    always #2.5 clk = ~clk;

    rstpin_status u_rstpin_status (
        .clk(clk), .rst_n(rst_n), .ext_rst_n_i(ext_rst_n_i),
        .mode_wr_i(mode_wr_i), .mode_ue_i(mode_ue_i), .mode_ie_i(mode_ie_i),
        .stat_rd_i(stat_rd_i), .stat_rdata_o(stat_rdata_o),
        .swrst_req_i(swrst_req_i), .swrst_done_i(swrst_done_i),
        .swrst_go_o(swrst_go_o), .rtype_ld_i(rtype_ld_i), .rtype_i(rtype_i),
        .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_mode(input logic ue, input logic ie);
        mode_ue_i = ue; mode_ie_i = ie; mode_wr_i = 1'b1;
        step(1);
        mode_wr_i = 1'b0;
    endtask

    task automatic do_read();
        stat_rd_i = 1'b1;
        step(1);
        stat_rd_i = 1'b0;
    endtask

    task automatic t_reset_R10();
        check("R10 status", stat_rdata_o, 32'h0001_0000);
        check("R10 irq", {31'd0, irq_o}, 32'd0);
        check("R10 go", {31'd0, swrst_go_o}, 32'd0);
    endtask

    task automatic t_sync_level_R1_R2();
        ext_rst_n_i = 1'b0;
        step(1);
        check("R1 level after one edge", {31'd0, stat_rdata_o[16]}, 32'd1);
        step(1);
        check("R1 level after two edges", {31'd0, stat_rdata_o[16]}, 32'd0);
        step(1);
        check("R3 flag set", {31'd0, stat_rdata_o[0]}, 32'd1);
        check("R4 irq off with mode 00", {31'd0, irq_o}, 32'd0);
        ext_rst_n_i = 1'b1;
        step(2);
        check("R2 level back high", {31'd0, stat_rdata_o[16]}, 32'd1);
        check("R3 flag sticky", {31'd0, stat_rdata_o[0]}, 32'd1);
    endtask

    task automatic t_irq_gate_R4();
        set_mode(1'b1, 1'b1);
        check("R4 irq off when ue=1", {31'd0, irq_o}, 32'd0);
        set_mode(1'b0, 1'b1);
        check("R4 irq on when ue=0 ie=1", {31'd0, irq_o}, 32'd1);
        set_mode(1'b0, 1'b0);
        check("R4 irq off when ie=0", {31'd0, irq_o}, 32'd0);
        set_mode(1'b0, 1'b1);
    endtask

    task automatic t_read_clear_R5();
        do_read();
        check("R5 flag cleared", {31'd0, stat_rdata_o[0]}, 32'd0);
        check("R5 irq cleared", {31'd0, irq_o}, 32'd0);
    endtask

    task automatic t_set_wins_R8();
        ext_rst_n_i = 1'b0;
        step(2);
        do_read();
        check("R8 set wins over read", {31'd0, stat_rdata_o[0]}, 32'd1);
        check("R8 irq", {31'd0, irq_o}, 32'd1);
        ext_rst_n_i = 1'b1;
        step(3);
        do_read();
        check("R5 second read clears", {31'd0, stat_rdata_o[0]}, 32'd0);
    endtask

    task automatic t_swrst_R6_R9();
        swrst_req_i = 1'b1;
        #1;
        check("R6 go pulse", {31'd0, swrst_go_o}, 32'd1);
        step(1);
        swrst_req_i = 1'b0;
        check("R6 busy set", {31'd0, stat_rdata_o[17]}, 32'd1);
        swrst_req_i = 1'b1;
        #1;
        check("R9 no go while busy", {31'd0, swrst_go_o}, 32'd0);
        step(1);
        swrst_req_i = 1'b0;
        check("R9 still busy", {31'd0, stat_rdata_o[17]}, 32'd1);
        swrst_done_i = 1'b1;
        step(1);
        swrst_done_i = 1'b0;
        check("R6 busy cleared", {31'd0, stat_rdata_o[17]}, 32'd0);
    endtask

    task automatic t_rtype_R7();
        rtype_i = 3'b101; rtype_ld_i = 1'b1;
        step(1);
        rtype_ld_i = 1'b0;
        check("R7 type loaded", {29'd0, stat_rdata_o[10:8]}, 32'd5);
        rtype_i = 3'b010;
        step(2);
        check("R7 type holds", {29'd0, stat_rdata_o[10:8]}, 32'd5);
        check("R10 layout word", stat_rdata_o, 32'h0001_0500);
    endtask

    initial begin
        step(4);
        rst_n = 1'b1;
        step(1);
        t_reset_R10();
        t_sync_level_R1_R2();
        t_irq_gate_R4();
        t_read_clear_R5();
        t_set_wins_R8();
        t_swrst_R6_R9();
        t_rtype_R7();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule